// File: doc/BRIEF.md
# Regulator Recharge Interval Monitor

This block decides when a sleep-mode supply rail gets its next recharge pulse, and it keeps a record of how well the rail held its charge between pulses. It runs directly on the 32 kHz low-frequency clock, so one clock cycle is one tick. A 2-bit mode selects the scheduling policy:

- **Off:** no pulses are issued.
- **Static timer:** the interval is a fixed value built from a mantissa and an exponent.
- **Adaptive timer:** the interval starts from the static value, grows while the rail stays healthy and shrinks when it sags.
- **Comparator:** an external comparator asks for each recharge.

Each time a recharge starts, the block samples a rail-OK input and shifts that sample into a short history. If the rail was still healthy, the block compares the elapsed interval with the longest healthy interval seen so far and keeps the larger. Software reads and writes a configuration word and a status word through a plain register port. Writing the status word clears the recorded maximum.

Top module: `recharge_monitor`

## Requirements
- R1: After a synchronous active-low reset, `recharge_o` is 0, the mode is off (code 00), and both registers read 0.
- R2: The configuration register is at address 0. Its fields are mode [1:0] (00 off, 01 static, 10 adaptive, 11 comparator), interval mantissa [6:2], interval exponent [9:7], maximum mantissa [14:10] and maximum exponent [17:15]. It reads back as written, with the upper bits 0. The status register is at address 1. It holds the maximum healthy span in [15:0] and the sample history in [19:16].
- R3: In static mode the interval is (mantissa+1) shifted left by the exponent, in ticks. The first pulse comes that many cycles after the configuration-write edge, and later pulses come at the same spacing. A configuration write restarts the tick counter and suppresses any pulse on that edge.
- R4: In adaptive mode the first interval after a configuration write is the static value. After each pulse, the next interval is twice the previous one if the rail sample was OK, capped at the maximum interval. Otherwise it is half the previous one, with a floor of one tick. The maximum interval uses the same formula on its own pair.
- R5: In comparator mode, a request sampled high at a clock edge produces a pulse during the following cycle.
- R6: In off mode there is no pulse, whatever `cmp_req` and `rail_ok_i` do, and the history and the maximum hold their values.
- R7: At every recharge start the history shifts left by one and bit 0 takes `rail_ok_i`: 1 means the rail was OK, 0 means it was below its threshold. At all other times the history holds.
- R8: The span of a recharge is the number of ticks since the previous recharge or since the last configuration write, whichever came later. The span saturates at 65535. The maximum field takes the span only when `rail_ok_i` is 1 at that recharge and the span is larger than the stored value.
- R9: Any write to address 1 clears the maximum field to 0 and leaves the history unchanged. The clear wins over an update on the same edge.
- R10: A pulse is exactly one cycle long. Pulses are back to back only when the interval is one tick or requests arrive on consecutive edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 kHz tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 configuration, 1 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| cmp_req | input | 1 | Recharge request from the external comparator |
| rail_ok_i | input | 1 | Rail above its OK threshold |
| recharge_o | output | 1 | One-tick recharge pulse |

## Verification
Static mode is run with two different mantissa/exponent pairs, one of them with a nonzero exponent, so that a wrong shift or a missing +1 moves the pulse cycles. It is also run with a one-tick interval, which exposes counter off-by-one errors. Adaptive mode is run once with the rail always OK, which shows doubling and the cap, and once with the rail always low, which shows halving down to the one-tick floor. Comparator requests are spaced unevenly and mixed with healthy and unhealthy samples, so the history order and the rule that only healthy spans count can both be seen. Off mode is driven with requests held high to show that nothing moves. Status writes are placed between tests to separate the clear from the history.

// File: rtl/rrm_pkg.sv
// Shared types and constants for the recharge interval monitor.
// Assumes the mantissa/exponent widths give intervals below 2**SPAN_W.
package rrm_pkg;
    localparam int MANT_W = 5;
    localparam int EXP_W  = 3;
    localparam int HIST_W = 4;
    localparam int SPAN_W = 16;
    localparam int IVL_W  = MANT_W + (1 << EXP_W);
    localparam int CFG_W  = 2 + 2 * (MANT_W + EXP_W);

    typedef enum logic [1:0] {
        MODE_OFF    = 2'b00,
        MODE_STATIC = 2'b01,
        MODE_ADAPT  = 2'b10,
        MODE_CMP    = 2'b11
    } rmode_e;

    typedef struct packed {
        logic [EXP_W-1:0]  max_e;
        logic [MANT_W-1:0] max_m;
        logic [EXP_W-1:0]  per_e;
        logic [MANT_W-1:0] per_m;
        rmode_e            mode;
    } cfg_t;

    // Interval in ticks: (mantissa + 1) << exponent.
    function automatic logic [IVL_W-1:0] ivl_of(input logic [MANT_W-1:0] m,
                                                 input logic [EXP_W-1:0] e);
        logic [IVL_W-1:0] t;
        t = IVL_W'(m) + IVL_W'(1);
        return t << e;
    endfunction
endpackage

// File: rtl/rrm_regs.sv
// Register port: holds the configuration word, decodes writes and builds
// read data. Assumes single-cycle writes and combinational reads.
module rrm_regs
    import rrm_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [SPAN_W-1:0] max_used,
    input  logic [HIST_W-1:0] hist,
    output cfg_t              cfg,
    output logic              cfg_wr,
    output logic              stat_wr,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam logic [ADDR_W-1:0] CFG_ADDR  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(1);
    localparam int STAT_W = SPAN_W + HIST_W;

    cfg_t cfg_q;

    // Write decode for both registers.
    always_comb begin
        cfg_wr  = reg_we && (reg_addr == CFG_ADDR);
        stat_wr = reg_we && (reg_addr == STAT_ADDR);
    end

    // Configuration storage.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_wr) cfg_q <= cfg_t'(reg_wdata[CFG_W-1:0]);
    end

    assign cfg = cfg_q;

    // Read data multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CFG_ADDR)       reg_rdata[CFG_W-1:0]  = cfg_q;
        else if (reg_addr == STAT_ADDR) reg_rdata[STAT_W-1:0] = {hist, max_used};
    end
endmodule

// File: rtl/rrm_timer.sv
// Recharge scheduler: a saturating tick counter, the adaptive interval and
// the mode-dependent fire decision. A configuration write restarts the counter
// and blocks a fire on that edge. The pulse output is registered.
module rrm_timer
    import rrm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cfg_t              cfg,
    input  logic              cfg_wr,
    input  logic              cmp_req,
    input  logic              rail_ok_i,
    output logic              fire,
    output logic [SPAN_W-1:0] span,
    output logic              recharge_o
);
    localparam logic [SPAN_W-1:0] SPAN_TOP = '1;

    logic [SPAN_W-1:0] cnt_q;
    logic [IVL_W-1:0]  cur_q;
    logic              fresh_q;
    logic              pulse_q;
    logic [IVL_W-1:0]  base_ivl, max_ivl, eff_ivl, next_ivl;
    logic [IVL_W:0]    dbl_ivl;
    logic              hit;

    // Intervals from the configuration, and the one in force now.
    always_comb begin
        base_ivl = ivl_of(cfg.per_m, cfg.per_e);
        max_ivl  = ivl_of(cfg.max_m, cfg.max_e);
        eff_ivl  = (cfg.mode == MODE_ADAPT && !fresh_q) ? cur_q : base_ivl;
        hit      = ({1'b0, cnt_q} + 1'b1) >= (SPAN_W + 1)'(eff_ivl);
    end

    // Fire decision per mode.
    always_comb begin
        unique case (cfg.mode)
            MODE_STATIC, MODE_ADAPT: fire = hit;
            MODE_CMP:                fire = cmp_req;
            default:                 fire = 1'b0;
        endcase
        if (cfg_wr) fire = 1'b0;
    end

    // Span of the recharge that fires now, saturating.
    assign span = (cnt_q == SPAN_TOP) ? SPAN_TOP : cnt_q + 1'b1;

    // Next adaptive interval: double capped at the maximum, or half floored at 1.
    always_comb begin
        dbl_ivl = {eff_ivl, 1'b0};
        if (rail_ok_i)
            next_ivl = (dbl_ivl > (IVL_W + 1)'(max_ivl)) ? max_ivl : dbl_ivl[IVL_W-1:0];
        else
            next_ivl = (eff_ivl > IVL_W'(1)) ? (eff_ivl >> 1) : IVL_W'(1);
    end

    // Tick counter since the last recharge or configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_wr || fire) cnt_q <= '0;
        else if (cnt_q != SPAN_TOP)   cnt_q <= cnt_q + 1'b1;
    end

    // Adaptive interval state and reload flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q   <= IVL_W'(1);
            fresh_q <= 1'b1;
        end else if (cfg_wr) begin
            fresh_q <= 1'b1;
        end else if (fire) begin
            cur_q   <= next_ivl;
            fresh_q <= 1'b0;
        end
    end

    // Registered one-tick pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= fire;
    end

    assign recharge_o = pulse_q;
endmodule

// File: rtl/rrm_history.sv
// Sample history and maximum healthy span. Both update only on a fire
// strobe. A status write clears the maximum and takes priority.
module rrm_history
    import rrm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              rail_ok_i,
    input  logic [SPAN_W-1:0] span,
    input  logic              stat_wr,
    output logic [HIST_W-1:0] hist,
    output logic [SPAN_W-1:0] max_used
);
    logic [HIST_W-1:0] hist_q;
    logic [SPAN_W-1:0] max_q;

    // One flop per history bit: bit 0 takes the sample, the others shift up.
    for (genvar i = 0; i < HIST_W; i++) begin : g_hist
        always_ff @(posedge clk) begin
            if (!rst_n)    hist_q[i] <= 1'b0;
            else if (fire) hist_q[i] <= (i == 0) ? rail_ok_i : hist_q[(i == 0) ? 0 : i - 1];
        end
    end

    // Longest healthy span, cleared by a status write.
    always_ff @(posedge clk) begin
        if (!rst_n || stat_wr)                         max_q <= '0;
        else if (fire && rail_ok_i && (span > max_q))  max_q <= span;
    end

    assign hist     = hist_q;
    assign max_used = max_q;
endmodule

// File: rtl/recharge_monitor.sv
// Top of the recharge interval monitor: register port, scheduler and
// history/maximum tracker. The clock is the 32 kHz tick itself.
module recharge_monitor
    import rrm_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              cmp_req,
    input  logic              rail_ok_i,
    output logic              recharge_o
);
    cfg_t              cfg;
    logic              cfg_wr, stat_wr, fire;
    logic [SPAN_W-1:0] span, max_used;
    logic [HIST_W-1:0] hist;

    rrm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .max_used(max_used), .hist(hist), .cfg(cfg),
        .cfg_wr(cfg_wr), .stat_wr(stat_wr), .reg_rdata(reg_rdata)
    );

    rrm_timer timer_i (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .cfg_wr(cfg_wr), .cmp_req(cmp_req),
        .rail_ok_i(rail_ok_i), .fire(fire), .span(span), .recharge_o(recharge_o)
    );

    rrm_history hist_i (
        .clk(clk), .rst_n(rst_n), .fire(fire), .rail_ok_i(rail_ok_i), .span(span),
        .stat_wr(stat_wr), .hist(hist), .max_used(max_used)
    );
endmodule

// File: rtl/recharge_monitor_chk.sv
// Property checker for the recharge interval monitor, bound to the top.
module recharge_monitor_chk
    import rrm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input rmode_e            mode,
    input logic              cfg_wr,
    input logic              stat_wr,
    input logic              cmp_req,
    input logic              rail_ok_i,
    input logic              recharge_o,
    input logic [HIST_W-1:0] hist,
    input logic [SPAN_W-1:0] max_used
);
    // R6: off mode issues no pulse
    a_r6_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF && !cfg_wr) |=> !recharge_o);

    // R5: a comparator request gives a pulse next cycle
    a_r5_cmp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CMP && cmp_req && !cfg_wr) |=> recharge_o);

    // R7: newest history bit is the rail sample at the recharge edge
    a_r7_hist_newest: assert property (@(posedge clk) disable iff (!rst_n)
        recharge_o |-> (hist[0] == $past(rail_ok_i)));

    // R7: history holds when no recharge started
    a_r7_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !recharge_o |-> $stable(hist));

    // R9: a status write clears the maximum
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> (max_used == '0));

    // R8: the maximum never falls except by a clear
    a_r8_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> (max_used >= $past(max_used)));
endmodule

bind recharge_monitor recharge_monitor_chk chk_i (
    .clk(clk), .rst_n(rst_n), .mode(cfg.mode), .cfg_wr(cfg_wr), .stat_wr(stat_wr),
    .cmp_req(cmp_req), .rail_ok_i(rail_ok_i), .recharge_o(recharge_o),
    .hist(hist), .max_used(max_used)
);

// File: tb/recharge_monitor_tb_top.sv
// Scoreboard bench: the driver pushes expected pulse cycles, the monitor pops
// and compares them at each observed pulse; register reads are checked directly.
module recharge_monitor_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cmp_req = 1'b0;
    logic        rail_ok_i = 1'b0;
    logic        recharge_o;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    int exp_q[$];
    bit done = 1'b0;

    recharge_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_req(cmp_req),
        .rail_ok_i(rail_ok_i), .recharge_o(recharge_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    // Monitor: every observed pulse must match the next expected cycle.
    always @(negedge clk) begin
        if (rst_n && recharge_o && !done) begin
            if (exp_q.size() == 0) check("R6/R10 unexpected pulse", cyc, -1);
            else check("R3/R4/R5 pulse cycle", cyc, exp_q.pop_front());
        end
    end

    // Write at the current negedge; returns at the next negedge with the edge index.
    task automatic wr(input logic [1:0] a, input logic [31:0] d, output int w);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        w = cyc + 1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input int expv, input string req);
        reg_addr = a;
        #1;
        check(req, reg_rdata, expv);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int w;
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        check("R1 recharge_o", recharge_o, 0);
        rd(2'd0, 0, "R1 config");
        rd(2'd1, 0, "R1 status");

        // R3: static, mantissa 4 exponent 0 -> 5 ticks, rail OK
        rail_ok_i = 1'b1;
        wr(2'd0, 32'h11, w);
        for (int k = 1; k <= 3; k++) exp_q.push_back(w + 5 * k);
        rd(2'd0, 32'h11, "R2 config readback");
        idle(17);
        wr(2'd0, 32'h0, w);
        check("R3 pulses consumed", exp_q.size(), 0);
        rd(2'd1, 32'h70005, "R7/R8 status after static");

        // R3: static, mantissa 1 exponent 2 -> 8 ticks, rail low
        rail_ok_i = 1'b0;
        wr(2'd0, 32'h105, w);
        exp_q.push_back(w + 8); exp_q.push_back(w + 16);
        idle(17);
        wr(2'd0, 32'h0, w);
        check("R3 exponent pulses consumed", exp_q.size(), 0);
        rd(2'd1, 32'hC0005, "R8 low rail keeps max, R7 shift");

        // R9: clear maximum, history kept
        wr(2'd1, 32'h0, w);
        rd(2'd1, 32'hC0000, "R9 clear keeps history");

        // R4: adaptive, base 2 max 8, rail OK: spans 2,4,8,8
        rail_ok_i = 1'b1;
        wr(2'd0, 32'h1C06, w);
        exp_q.push_back(w + 2); exp_q.push_back(w + 6);
        exp_q.push_back(w + 14); exp_q.push_back(w + 22);
        idle(24);
        wr(2'd0, 32'h0, w);
        check("R4 doubling pulses consumed", exp_q.size(), 0);
        rd(2'd1, 32'hF0008, "R4 cap and R8 max");

        // R4: adaptive, base 8 max 16, rail low: spans 8,4,2,1,1
        rail_ok_i = 1'b0;
        wr(2'd0, 32'h3C1E, w);
        exp_q.push_back(w + 8); exp_q.push_back(w + 12); exp_q.push_back(w + 14);
        exp_q.push_back(w + 15); exp_q.push_back(w + 16);
        idle(16);
        wr(2'd0, 32'h0, w);
        check("R4 halving pulses consumed", exp_q.size(), 0);
        rd(2'd1, 32'h00008, "R4 halving status");
        wr(2'd1, 32'h0, w);
        rd(2'd1, 32'h0, "R9 second clear");

        // R5: comparator requests with spans 3 (OK), 7 (low), 20 (OK)
        wr(2'd0, 32'h3, w);
        idle(2);
        cmp_req = 1'b1; rail_ok_i = 1'b1; exp_q.push_back(w + 3);
        idle(1);
        cmp_req = 1'b0;
        idle(6);
        cmp_req = 1'b1; rail_ok_i = 1'b0; exp_q.push_back(w + 10);
        idle(1);
        cmp_req = 1'b0;
        idle(19);
        cmp_req = 1'b1; rail_ok_i = 1'b1; exp_q.push_back(w + 30);
        idle(1);
        cmp_req = 1'b0;
        idle(3);
        check("R5 comparator pulses consumed", exp_q.size(), 0);
        rd(2'd1, 32'h50014, "R5/R8 comparator status");

        // R10: one-tick static interval, write on third edge suppresses it
        wr(2'd0, 32'h1, w);
        exp_q.push_back(w + 1); exp_q.push_back(w + 2);
        idle(2);
        wr(2'd0, 32'h0, w);
        idle(2);
        check("R10 one-tick pulses consumed", exp_q.size(), 0);
        rd(2'd1, 32'h70014, "R10 one-tick status");

        // R6: off mode ignores requests and rail changes
        cmp_req = 1'b1;
        for (int k = 0; k < 30; k++) begin
            rail_ok_i = k[0];
            idle(1);
        end
        cmp_req = 1'b0;
        check("R6 recharge_o low", recharge_o, 0);
        rd(2'd1, 32'h70014, "R6 status held in off mode");
        rd(2'd2, 0, "R2 unused address reads zero");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule